// File: doc/BRIEF.md
# Timed-Access Guarded Flash Operation Trigger

This block stands between a processor's register bus and a flash-operation engine. Two bits are protected: an enable bit that permits flash operations, and a go bit that starts one. A write to either bit counts only when it lands in a short window that opens after the key register receives the exact byte pair 0xAA and then 0x55. A write outside that window, or after a broken key sequence, leaves both bits unchanged.

When an accepted go write finds the enable bit set and no operation running, the block sends a one-cycle start pulse to the engine. It then holds the processor until the engine returns a one-cycle done pulse, so that execution resumes with the next instruction. The go bit never stores a value and always reads back as 0. The block also requests the internal high-speed oscillator whenever flash operations are enabled or running. The lock configuration input has no effect on any of this.

Top module: `flash_trig_guard`

## Requirements
- R1: After a synchronous active-low reset, the enable bit reads 0, cpu_hold and fop_start are 0, and the key sequence is idle, so a protected write made right after reset is ignored.
- R2: Two consecutive bus writes to the key address (0x10), 0xAA then 0x55, open a window. The first write inside that window to the control address (0x11) sets the enable bit to wdata bit 0, and the control address reads back {7'b0, enable}.
- R3: While the sequence waits for its first byte, a key write of any value other than 0xAA returns it to idle. While it waits for its second byte, a key write other than 0x55, or a bus write to any other address, also returns it to idle. A protected write made after a broken sequence leaves the protected bits unchanged.
- R4: The window covers the 4 clock cycles that follow the cycle of the 0x55 write. A protected write in the 4th of those cycles is honoured, and one in the 5th is ignored.
- R5: Only the first protected write inside a window is honoured. The window then closes, and a second protected write is ignored.
- R6: An honoured write to the trigger address (0x12) with wdata bit 0 set, made while the enable bit is 1 and nothing is running, produces a single-cycle fop_start in the following cycle. The trigger address always reads 0.
- R7: While the enable bit is 0, an honoured trigger write produces no fop_start and no cpu_hold.
- R8: cpu_hold rises in the same cycle as fop_start. It stays high until the cycle after a fop_done pulse is sampled, and then falls.
- R9: A trigger write honoured while an operation is running produces no further fop_start. The hold ends after the first fop_done.
- R10: osc_req equals enable OR running OR NOT ext_clk_sel, so it is dropped only when the enable bit is 0, nothing is running and the external clock is selected.
- R11: lock_cfg has no effect: triggers, the enable bit and the hold behave the same with lock_cfg at 1.
- R12: A fop_done pulse arriving while no operation is running is ignored and does not end a later operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cpu_hold | output | 1 | Stalls the processor's program counter |
| fop_start | output | 1 | One-cycle start pulse to the flash engine |
| fop_done | input | 1 | One-cycle completion pulse from the flash engine |
| ext_clk_sel | input | 1 | High when the system runs from an external clock |
| osc_req | output | 1 | Internal high-speed oscillator request |
| lock_cfg | input | 1 | Lock configuration, has no effect on operations |

## Verification
A write sampled at an edge changes the enable bit and the read data right after that same edge. fop_start and cpu_hold change one edge after the trigger write, and cpu_hold falls one edge after the done pulse. osc_req follows the registered state and ext_clk_sel with no further delay. The bench runs a reference model that advances at each rising edge on the inputs sampled there, and it compares every output 1.5 ns after that edge. Its scenario checks are placed at falling edges, where the counted number of edges has already passed, so each result is looked at only once it is due.

// File: rtl/flt_pkg.sv
`timescale 1ns/1ps
// Package: shared state encodings for the timed-access flash trigger.
// Assumes: consumed by every module of flash_trig_guard.
package flt_pkg;
    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } ul_state_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_BUSY = 1'b1
    } sq_state_t;
endpackage

// File: rtl/ta_unlock.sv
`timescale 1ns/1ps
// Module: ta_unlock
// Tracks the two-byte key sequence and opens a short window for one
// protected write. Assumes that at most one bus write happens per cycle and
// that key_wr, prot_wr and other_wr are mutually exclusive decodes of it.
module ta_unlock
    import flt_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  KEY_FIRST  = 8'hAA,
    parameter logic [7:0]  KEY_SECOND = 8'h55,
    parameter int          WINDOW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic              prot_wr,
    input  logic              other_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              grant
);
    localparam int WIN_W = $clog2(WINDOW + 1);

    ul_state_t        state_q, state_d;
    logic [WIN_W-1:0] win_q, win_d;
    logic             is_first, is_second;

    // Compare the written byte against the two key values.
    always_comb begin
        is_first  = (wdata[7:0] == KEY_FIRST);
        is_second = (wdata[7:0] == KEY_SECOND);
    end

    // A protected write is honoured only while the window is open.
    assign grant = (state_q == UL_OPEN) && prot_wr;

    // Next-state logic for the key sequence and the window countdown.
    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        unique case (state_q)
            UL_IDLE: begin
                if (key_wr && is_first) state_d = UL_HALF;
            end
            UL_HALF: begin
                if (key_wr && is_second) begin
                    state_d = UL_OPEN;
                    win_d   = WIN_W'(WINDOW);
                end else if (key_wr || prot_wr || other_wr) begin
                    state_d = UL_IDLE;
                end
            end
            UL_OPEN: begin
                if (key_wr) begin
                    state_d = is_first ? UL_HALF : UL_IDLE;
                end else if (prot_wr) begin
                    state_d = UL_IDLE;
                end else if (win_q == WIN_W'(1)) begin
                    state_d = UL_IDLE;
                end else begin
                    win_d = win_q - WIN_W'(1);
                end
            end
            default: state_d = UL_IDLE;
        endcase
    end

    // State and window registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UL_IDLE;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
        end
    end

    // R5: an honoured write closes the window.
    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant);

    // R2: the window opens only after a second-key write.
    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == UL_OPEN) && !$past(state_q == UL_OPEN))
            |-> $past(key_wr && is_second));

    // R4: the window never holds more than WINDOW cycles.
    p_window_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UL_OPEN) |-> (win_q != '0) && (win_q <= WIN_W'(WINDOW)));
endmodule

// File: rtl/guard_ctrl_reg.sv
`timescale 1ns/1ps
// Module: guard_ctrl_reg
// Holds the protected enable bit. It is written only when the unlock logic
// grants the current protected write and that write targets the control
// address. Assumes the grant is already qualified by the address decode.
module guard_ctrl_reg #(
    parameter int DATA_W     = 8,
    parameter int ENABLE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_grant,
    input  logic [DATA_W-1:0] wdata,
    output logic              enable
);
    // Enable bit register; it changes only on a granted write.
    always_ff @(posedge clk) begin
        if (!rst_n)          enable <= 1'b0;
        else if (ctrl_grant) enable <= wdata[ENABLE_BIT];
    end

    // R2: the enable bit never changes without a grant.
    p_enable_guarded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_grant) |-> $stable(enable));
endmodule

// File: rtl/op_sequencer.sv
`timescale 1ns/1ps
// Module: op_sequencer
// Starts one flash operation per accepted trigger, holds the processor while
// it runs and releases it after the engine's done pulse. Assumes fop_done is
// a single-cycle pulse. lock_cfg is taken in only to show that it plays no
// part.
module op_sequencer
    import flt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_req,
    input  logic enable,
    input  logic fop_done,
    input  logic lock_cfg,
    output logic fop_start,
    output logic busy
);
    sq_state_t state_q;
    logic      launch;

    // A trigger is acted on only when it is enabled and nothing is running.
    assign launch = trig_req && enable && (state_q == SQ_IDLE);
    assign busy   = (state_q == SQ_BUSY);

    // Operation state and the registered start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            fop_start <= 1'b0;
        end else begin
            fop_start <= launch;
            unique case (state_q)
                SQ_IDLE: if (launch)   state_q <= SQ_BUSY;
                SQ_BUSY: if (fop_done) state_q <= SQ_IDLE;
                default:               state_q <= SQ_IDLE;
            endcase
        end
    end

    // R6: the start output is a single-cycle pulse.
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fop_start |=> !fop_start);

    // R8: the hold is high whenever a start is issued.
    p_hold_with_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fop_start |-> busy);

    // R9: no start while an operation runs on without done.
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fop_done) |=> !fop_start);

    // R7: a start requires the enable bit in the cycle before.
    p_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fop_start |-> $past(enable));

    // R11: lock_cfg does not keep an eligible trigger from starting.
    p_lock_no_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_req && enable && !busy && lock_cfg) |=> fop_start);
endmodule

// File: rtl/flash_trig_guard.sv
`timescale 1ns/1ps
// Module: flash_trig_guard (top)
// Decodes the register bus, wires the key sequence, the enable register and
// the operation sequencer together, and drives the read data and the
// oscillator request. Assumes one bus write per cycle and reads that are
// combinational from bus_addr.
module flash_trig_guard #(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  KEY_ADDR   = 8'h10,
    parameter logic [7:0]  CTRL_ADDR  = 8'h11,
    parameter logic [7:0]  TRIG_ADDR  = 8'h12,
    parameter logic [7:0]  KEY_FIRST  = 8'hAA,
    parameter logic [7:0]  KEY_SECOND = 8'h55,
    parameter int          WINDOW     = 4,
    parameter int          ENABLE_BIT = 0,
    parameter int          GO_BIT     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_hold,
    output logic              fop_start,
    input  logic              fop_done,
    input  logic              ext_clk_sel,
    output logic              osc_req,
    input  logic              lock_cfg
);
    logic sel_key, sel_ctrl, sel_trig;
    logic key_wr, prot_wr, other_wr;
    logic grant, enable, busy, trig_req;

    // Address decode of the current bus cycle.
    always_comb begin
        sel_key  = (bus_addr == ADDR_W'(KEY_ADDR));
        sel_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
        sel_trig = (bus_addr == ADDR_W'(TRIG_ADDR));
        key_wr   = bus_we && sel_key;
        prot_wr  = bus_we && (sel_ctrl || sel_trig);
        other_wr = bus_we && !sel_key && !sel_ctrl && !sel_trig;
    end

    ta_unlock #(
        .DATA_W     (DATA_W),
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND),
        .WINDOW     (WINDOW)
    ) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .prot_wr  (prot_wr),
        .other_wr (other_wr),
        .wdata    (bus_wdata),
        .grant    (grant)
    );

    guard_ctrl_reg #(
        .DATA_W     (DATA_W),
        .ENABLE_BIT (ENABLE_BIT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_grant (grant && sel_ctrl),
        .wdata      (bus_wdata),
        .enable     (enable)
    );

    assign trig_req = grant && sel_trig && bus_wdata[GO_BIT];

    op_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_req  (trig_req),
        .enable    (enable),
        .fop_done  (fop_done),
        .lock_cfg  (lock_cfg),
        .fop_start (fop_start),
        .busy      (busy)
    );

    // Read mux: only the enable bit is visible; key and go read as zero.
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) bus_rdata[ENABLE_BIT] = enable;
    end

    assign cpu_hold = busy;
    assign osc_req  = enable || busy || !ext_clk_sel;

    // R10: the oscillator is requested whenever flash operations are enabled.
    p_osc_on_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable || cpu_hold) |-> osc_req);

    // R6: the go bit always reads back as zero.
    p_go_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_trig |-> (bus_rdata == '0));
endmodule

// File: tb/test_flash_trig_guard.sv
`timescale 1ns/1ps
module test_flash_trig_guard;
    localparam logic [7:0] KA = 8'h10, CA = 8'h11, TA = 8'h12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic       bus_we = 1'b0, fop_done = 1'b0;
    logic       ext_clk_sel = 1'b1, lock_cfg = 1'b0;
    logic [7:0] bus_rdata;
    logic       cpu_hold, fop_start, osc_req;

    int checks = 0, errors = 0;
    bit started = 1'b0;

    // Reference model state.
    int  m_ul = 0, m_win = 0;
    bit  m_en = 0, m_busy = 0, m_start = 0;

    flash_trig_guard i_flash_trig_guard (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .cpu_hold(cpu_hold),
        .fop_start(fop_start), .fop_done(fop_done), .ext_clk_sel(ext_clk_sel),
        .osc_req(osc_req), .lock_cfg(lock_cfg));

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: advances on each rising edge, outputs compared 1.5 ns later.
    always @(posedge clk) begin
        bit prot, grant, trig;
        prot  = bus_we && (bus_addr == CA || bus_addr == TA);
        grant = (m_ul == 2) && prot;
        trig  = grant && bus_addr == TA && bus_wdata[0] && m_en && !m_busy;
        if (!rst_n) begin
            m_ul = 0; m_win = 0; m_en = 0; m_busy = 0; m_start = 0;
        end else begin
            m_start = trig;
            if (m_busy && fop_done) m_busy = 0;
            else if (trig) m_busy = 1;
            if (grant && bus_addr == CA) m_en = bus_wdata[0];
            if (bus_we && bus_addr == KA) begin
                if (m_ul == 1 && bus_wdata == 8'h55) begin m_ul = 2; m_win = 4; end
                else m_ul = (bus_wdata == 8'hAA && m_ul != 1) ? 1 : 0;
            end else if (m_ul == 1 && bus_we) m_ul = 0;
            else if (m_ul == 2) begin
                if (grant || m_win == 1) m_ul = 0;
                else m_win--;
            end
        end
        started = 1'b1;
        #1.5;
        chk("R6 fop_start", fop_start, m_start);
        chk("R8 cpu_hold", cpu_hold, m_busy);
        chk("R10 osc_req", osc_req, m_en || m_busy || !ext_clk_sel);
        chk("R2 bus_rdata", bus_rdata, (bus_addr == CA) ? m_en : 0);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic unlock();
        wr(KA, 8'hAA);
        wr(KA, 8'h55);
    endtask

    task automatic rd(input string req, input logic [7:0] a, input int exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        @(negedge clk);
    endtask

    task automatic done_pulse();
        fop_done = 1'b1;
        @(negedge clk);
        fop_done = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1 hold after reset", cpu_hold, 0);
        chk("R1 start after reset", fop_start, 0);
        rd("R1 enable after reset", CA, 0);
        rst_n = 1'b1;
        wr(CA, 8'h01);
        rd("R1 protected write without key", CA, 0);

        unlock(); wr(CA, 8'h01);
        rd("R2 enable set after key", CA, 1);

        wr(KA, 8'hAA); wr(KA, 8'hAA); wr(KA, 8'h55); wr(CA, 8'h00);
        rd("R3 repeated first byte", CA, 1);
        wr(KA, 8'h55); wr(KA, 8'hAA); wr(CA, 8'h00);
        rd("R3 reversed order", CA, 1);
        wr(KA, 8'hAA); wr(8'h20, 8'h00); wr(KA, 8'h55); wr(CA, 8'h00);
        rd("R3 foreign write between bytes", CA, 1);

        unlock(); idle(3); wr(CA, 8'h00);
        rd("R4 last window cycle honoured", CA, 0);
        unlock(); idle(4); wr(CA, 8'h01);
        rd("R4 cycle after window ignored", CA, 0);

        unlock(); wr(CA, 8'h01); wr(CA, 8'h00);
        rd("R5 second write in window ignored", CA, 1);

        unlock(); wr(TA, 8'h01);
        chk("R6 start pulse", fop_start, 1);
        chk("R8 hold with start", cpu_hold, 1);
        rd("R6 go reads zero", TA, 0);
        chk("R6 start single cycle", fop_start, 0);
        idle(2);
        chk("R8 hold while running", cpu_hold, 1);
        done_pulse();
        chk("R8 hold released after done", cpu_hold, 0);

        unlock(); wr(TA, 8'h01);
        unlock(); wr(TA, 8'h01);
        chk("R9 no restart while busy", fop_start, 0);
        done_pulse();
        chk("R9 hold ends after first done", cpu_hold, 0);

        unlock(); wr(CA, 8'h00);
        unlock(); wr(TA, 8'h01);
        chk("R7 no start when disabled", fop_start, 0);
        chk("R7 no hold when disabled", cpu_hold, 0);

        ext_clk_sel = 1'b1; idle(1);
        chk("R10 oscillator dropped", osc_req, 0);
        ext_clk_sel = 1'b0; idle(1);
        chk("R10 oscillator on internal clock", osc_req, 1);
        ext_clk_sel = 1'b1;
        unlock(); wr(CA, 8'h01);
        chk("R10 oscillator with enable", osc_req, 1);

        lock_cfg = 1'b1;
        unlock(); wr(TA, 8'h01);
        chk("R11 start with lock set", fop_start, 1);
        done_pulse();
        chk("R11 hold released with lock set", cpu_hold, 0);
        lock_cfg = 1'b0;

        done_pulse();
        chk("R12 idle done no hold", cpu_hold, 0);
        unlock(); wr(TA, 8'h01);
        idle(3);
        chk("R12 earlier done does not end operation", cpu_hold, 1);
        done_pulse();
        chk("R12 hold released by real done", cpu_hold, 0);

        idle(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule